// File: doc/BRIEF.md
# Four-Line Six-Level Subset Demapper

This block is the receive-side decision stage for a link that sends seven bits per symbol across four parallel lines, each driven at one of six amplitude levels. The six levels form two interleaved three-level subsets. Subset A is {-5, -1, +3}·U and subset B is {-3, +1, +5}·U. In every symbol all four lines use the same subset. The subset choice carries the seventh bit, and the position inside the subset on each pair of lines carries three bits. The block takes four digitized signed samples per symbol. It first decides which subset was sent and then recovers the six data bits.

The subset decision compares two sums over the four lines. One sum adds the squared distances to the nearest A level, the other adds the squared distances to the nearest B level. On each line the difference of the two squared distances is piecewise linear in the sample, and the breakpoints fall at the four slicer thresholds that data slicing needs anyway. The block therefore forms this difference from those same comparators, scaled down by 4U. Both hypotheses are sliced in parallel, each into a pair of 3-bit codes. The subset decision then selects one 6-bit word. Samples are registered on input, and the decided symbol is registered on output.

Top module: `subset_demap6`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly two rising clock edges, and a new symbol can be accepted on every cycle.
- R2: `out_bits[6]` is 0 for subset A (levels -5U, -U, +3U) and 1 for subset B (levels -3U, +U, +5U). The subset chosen is the one with the smaller sum, over all four lines, of the squared distance from the sample to the nearest level of that subset.
- R3: When the two summed distances are equal, subset A (`out_bits[6]`=0) is chosen.
- R4: Within the chosen subset, each line takes the index of its nearest level. Subset A maps +3U, -U, -5U to indices 0, 1, 2. Subset B maps -3U, +U, +5U to indices 0, 1, 2. A sample exactly halfway between two levels takes the more positive level.
- R5: `out_bits[5:3]` = 3·(index of line 3) + (index of line 2), and `out_bits[2:0]` = 3·(index of line 1) + (index of line 0).
- R6: A line pair whose indices are both 2 (the excluded outer corner) yields pair code 7, the code of its valid neighbour (2,1).
- R7: For each of the 128 symbols, driving its four subset levels with per-line noise of magnitude at most 7 (U=8) returns that symbol exactly.
- R8: Samples presented while `in_valid` is low are ignored. `out_bits` holds its last value whenever `out_valid` is low.
- R9: While reset is asserted, `out_valid` and `out_bits` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The four samples carry a symbol this cycle |
| rx_l0 | input | SW | Line 0 sample, signed two's complement |
| rx_l1 | input | SW | Line 1 sample, signed two's complement |
| rx_l2 | input | SW | Line 2 sample, signed two's complement |
| rx_l3 | input | SW | Line 3 sample, signed two's complement |
| out_valid | output | 1 | The decided symbol is present on out_bits |
| out_bits | output | 7 | Subset bit [6] and two 3-bit pair codes [5:0] |

## Verification
The checker follows the two-cycle valid timing and the holding of `out_bits` on idle cycles on every clock. It also watches a few fixed input patterns: the all-zero tie, the all-top-A pattern, the all-bottom-B pattern and the full A corner. Each time one of these appears, it checks the symbol that comes out two cycles later. Correct decoding of the whole constellation under noise needs the bench, because only the bench knows which symbol was sent. The same holds for threshold-edge samples, saturated inputs and the B-side corner, which the bench covers through its directed vectors.

// File: rtl/subset_demap6.sv
module subset_demap6 #(
  parameter int SW = 8,
  parameter int U  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] rx_l0,
  input  logic signed [SW-1:0] rx_l1,
  input  logic signed [SW-1:0] rx_l2,
  input  logic signed [SW-1:0] rx_l3,
  output logic                 out_valid,
  output logic [6:0]           out_bits
);
  localparam int NL   = 4;
  localparam int MW   = SW + 2;
  localparam int SUMW = MW + 2;
  localparam logic signed [SW-1:0] T_M3 = SW'(-3 * U);
  localparam logic signed [SW-1:0] T_M1 = SW'(-U);
  localparam logic signed [SW-1:0] T_P1 = SW'(U);
  localparam logic signed [SW-1:0] T_P3 = SW'(3 * U);
  localparam logic signed [MW-1:0] K2   = MW'(2 * U);
  localparam logic signed [MW-1:0] K4   = MW'(4 * U);

  logic signed [SW-1:0]   smp_q [NL];
  logic                   vld_q;
  logic [1:0]             idx_a [NL];
  logic [1:0]             idx_b [NL];
  logic signed [MW-1:0]   met   [NL];
  logic signed [SUMW-1:0] met_sum;
  logic                   pat_b;
  logic [5:0]             word_a, word_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      for (int i = 0; i < NL; i++) smp_q[i] <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        smp_q[0] <= rx_l0;
        smp_q[1] <= rx_l1;
        smp_q[2] <= rx_l2;
        smp_q[3] <= rx_l3;
      end
    end
  end

  for (genvar g = 0; g < NL; g++) begin : g_line
    logic ge_m3, ge_m1, ge_p1, ge_p3;
    logic signed [MW-1:0] xe;
    assign xe    = {{(MW-SW){smp_q[g][SW-1]}}, smp_q[g]};
    assign ge_m3 = smp_q[g] >= T_M3;
    assign ge_m1 = smp_q[g] >= T_M1;
    assign ge_p1 = smp_q[g] >= T_P1;
    assign ge_p3 = smp_q[g] >= T_P3;
    assign idx_a[g] = ge_p1 ? 2'd0 : (ge_m3 ? 2'd1 : 2'd2);
    assign idx_b[g] = ge_p3 ? 2'd2 : (ge_m1 ? 2'd1 : 2'd0);
    assign met[g] = !ge_m3 ? xe + K4 :
                    !ge_m1 ? -xe - K2 :
                    !ge_p1 ? xe :
                    !ge_p3 ? K2 - xe : xe - K4;
  end

  function automatic logic signed [SUMW-1:0] sx(input logic signed [MW-1:0] v);
    return {{(SUMW-MW){v[MW-1]}}, v};
  endfunction

  assign met_sum = sx(met[0]) + sx(met[1]) + sx(met[2]) + sx(met[3]);
  assign pat_b   = met_sum > 0;

  function automatic logic [2:0] pair_code(input logic [1:0] hi, input logic [1:0] lo);
    case ({hi, lo})
      4'b0000: return 3'd0;
      4'b0001: return 3'd1;
      4'b0010: return 3'd2;
      4'b0100: return 3'd3;
      4'b0101: return 3'd4;
      4'b0110: return 3'd5;
      4'b1000: return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

  assign word_a = {pair_code(idx_a[3], idx_a[2]), pair_code(idx_a[1], idx_a[0])};
  assign word_b = {pair_code(idx_b[3], idx_b[2]), pair_code(idx_b[1], idx_b[0])};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bits  <= '0;
    end else begin
      out_valid <= vld_q;
      if (vld_q) out_bits <= {pat_b, pat_b ? word_b : word_a};
    end
  end
endmodule

// File: rtl/subset_demap6_chk.sv
module subset_demap6_chk #(
  parameter int SW = 8,
  parameter int U  = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic signed [SW-1:0] rx_l0,
  input logic signed [SW-1:0] rx_l1,
  input logic signed [SW-1:0] rx_l2,
  input logic signed [SW-1:0] rx_l3,
  input logic                 out_valid,
  input logic [6:0]           out_bits
);
  logic all_zero, all_a_top, all_b_low, all_a_corner;
  assign all_zero     = rx_l0 == 0 && rx_l1 == 0 && rx_l2 == 0 && rx_l3 == 0;
  assign all_a_top    = rx_l0 == SW'(3 * U) && rx_l1 == SW'(3 * U) && rx_l2 == SW'(3 * U) && rx_l3 == SW'(3 * U);
  assign all_b_low    = rx_l0 == SW'(-3 * U) && rx_l1 == SW'(-3 * U) && rx_l2 == SW'(-3 * U) && rx_l3 == SW'(-3 * U);
  assign all_a_corner = rx_l0 == SW'(-5 * U) && rx_l1 == SW'(-5 * U) && rx_l2 == SW'(-5 * U) && rx_l3 == SW'(-5 * U);

  AST_VALID_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> ##1 out_valid); // R1
  AST_IDLE_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> ##1 !out_valid); // R1
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> $stable(out_bits)); // R8
  AST_TIE_PICKS_A: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && all_zero) |=> ##1 out_bits == 7'h24); // R3
  AST_A_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && all_a_top) |=> ##1 out_bits == 7'h00); // R5
  AST_B_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && all_b_low) |=> ##1 out_bits == 7'h40); // R2
  AST_A_CORNER_MAP: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && all_a_corner) |=> ##1 out_bits == 7'h3F); // R6
endmodule

bind subset_demap6 subset_demap6_chk #(.SW(SW), .U(U)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .rx_l0(rx_l0), .rx_l1(rx_l1), .rx_l2(rx_l2), .rx_l3(rx_l3),
  .out_valid(out_valid), .out_bits(out_bits)
);

// File: tb/test_subset_demap6.sv
module test_subset_demap6;
  localparam int U = 8;
  localparam int NDIR = 10;
  localparam logic [38:0] DIR_TAB [NDIR] = '{
    {8'h00, 8'h00, 8'h00, 8'h00, 7'h24},
    {8'hD8, 8'hD8, 8'hD8, 8'hD8, 7'h3F},
    {8'h28, 8'h28, 8'h28, 8'h28, 7'h7F},
    {8'h08, 8'h08, 8'h08, 8'h08, 7'h64},
    {8'h18, 8'h18, 8'h18, 8'h08, 7'h00},
    {8'h08, 8'hE8, 8'h28, 8'h08, 7'h5F},
    {8'h1F, 8'hF1, 8'hDD, 8'h12, 7'h0E},
    {8'h7F, 8'h7F, 8'h7F, 8'h7F, 7'h7F},
    {8'h80, 8'h80, 8'h80, 8'h80, 7'h3F},
    {8'hE8, 8'hE8, 8'h28, 8'h28, 7'h47}
  };
  localparam string DIR_REQ [NDIR] = '{"R3", "R6", "R6", "R2", "R4", "R5", "R4", "R2", "R6", "R6"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [7:0] rx [4] = '{default: '0};
  logic out_valid;
  logic [6:0] out_bits;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  subset_demap6 #(.SW(8), .U(U)) i_subset_demap6 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .rx_l0(rx[0]), .rx_l1(rx[1]), .rx_l2(rx[2]), .rx_l3(rx[3]),
    .out_valid(out_valid), .out_bits(out_bits)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lvl(input bit pb, input int idx);
    return pb ? (-3 + 4 * idx) * U : (3 - 4 * idx) * U;
  endfunction

  task automatic drive_symbol(input logic [6:0] s);
    int ix [4];
    ix[3] = int'(s[5:3]) / 3; ix[2] = int'(s[5:3]) % 3;
    ix[1] = int'(s[2:0]) / 3; ix[0] = int'(s[2:0]) % 3;
    for (int j = 0; j < 4; j++)
      rx[j] = 8'(lvl(s[6], ix[j]) + ((int'(s) * 7 + j * 5 + 3) % 15) - 7);
    in_valid = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [6:0] last;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 valid in reset", 8'(out_valid), 8'h00);
    chk(out_bits == 7'h00, "R9 bits in reset", 8'(out_bits), 8'h00);
    rst_n = 1'b1;

    // R7 R1: streamed noisy loopback of every symbol
    for (int k = 0; k < 130; k++) begin
      @(negedge clk);
      if (k >= 2)
        chk(out_valid && out_bits == 7'(k - 2), "R7 loopback", {out_valid, out_bits}, {1'b1, 7'(k - 2)});
      if (k < 128) drive_symbol(7'(k));
      else in_valid = 1'b0;
    end

    // directed vectors: tie, corners, thresholds, saturation
    for (int k = 0; k < NDIR + 2; k++) begin
      @(negedge clk);
      if (k >= 2)
        chk(out_valid && out_bits == DIR_TAB[k - 2][6:0], DIR_REQ[k - 2], {out_valid, out_bits}, {1'b1, DIR_TAB[k - 2][6:0]});
      if (k < NDIR) begin
        rx[3] = DIR_TAB[k][38:31]; rx[2] = DIR_TAB[k][30:23];
        rx[1] = DIR_TAB[k][22:15]; rx[0] = DIR_TAB[k][14:7];
        in_valid = 1'b1;
      end else in_valid = 1'b0;
    end

    // R8: samples without in_valid are ignored and the output holds
    last = out_bits;
    for (int k = 0; k < 4; k++) begin
      rx[0] = 8'sd40; rx[1] = 8'sd40; rx[2] = 8'sd40; rx[3] = 8'sd40;
      @(negedge clk);
      chk(!out_valid && out_bits == last, "R8 idle hold", {out_valid, out_bits}, {1'b0, last});
    end

    // R1: single isolated symbol, output exactly two edges later
    drive_symbol(7'h55);
    @(negedge clk);
    in_valid = 1'b0;
    chk(!out_valid, "R1 not early", 8'(out_valid), 8'h00);
    @(negedge clk);
    chk(out_valid && out_bits == 7'h55, "R1 latency", {out_valid, out_bits}, {1'b1, 7'h55});
    @(negedge clk);
    chk(!out_valid, "R1 single pulse", 8'(out_valid), 8'h00);

    // R9: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk(!out_valid && out_bits == 7'h00, "R9 reassert", {out_valid, out_bits}, 8'h00);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule